// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode and Mark/Rewind

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words are stored on write-clock edges and taken out on read-clock edges. Pointers cross between the two clock domains as Gray code through two-flop synchronisers. The status flags are therefore conservative: a flag may report full or empty for a few cycles longer than strictly needed, and it never reports space or data that does not exist.

A master reset selects one of two read timings from the mode pin. In standard timing a word reaches the output only when a read asks for it. In fall-through timing the oldest word is placed on the output without any request, and a read consumes it. A partial reset empties the buffer and keeps the timing already chosen.

A consumer can mark a word it is reading and later rewind to it, so that everything from the marked word onward is delivered again. While a mark is held, the write side counts the marked word as the oldest occupied entry, so data that may be replayed is never overwritten.

Top module: `dcfifo_rewind`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge when `wen_n` is low and the buffer is not full; words leave in the order they were stored.
- R2: In standard timing (mode bit 0), `dout` changes only on a rising `rclk` edge where `ren_n` is low and the buffer is not empty, and then shows the oldest unread word; a word written into an empty buffer stays off `dout` until such a read.
- R3: In fall-through timing (mode bit 1), a word written into an empty buffer appears on `dout` at the third rising `rclk` edge after its write edge, with `ren_n` high throughout. It stays there until a rising `rclk` edge with `ren_n` low consumes it, and the next word then follows on that same edge.
- R4: `mode_sel` is sampled only while `mrst_n` is low; 0 selects standard timing and 1 selects fall-through timing. In standard timing `rd_stat`=1 means empty and `wr_stat`=1 means full. In fall-through timing `rd_stat`=1 means a valid word is on `dout` and `wr_stat`=1 means a write would be accepted.
- R5: A low `prst_n` sampled on the clock edges empties the buffer and clears any mark, but leaves the timing mode unchanged whatever `mode_sel` holds.
- R6: On the first rising `rclk` edge where `mark_i` is high, the word being read at that edge is recorded. In standard timing this is the word a read on that edge would return; in fall-through timing it is the word on `dout`. The mark stays active while `mark_i` is high.
- R7: A low `rt_n` on a rising `rclk` edge while a mark is active returns the read position to the marked word, so all words from it onward are read again in order; in fall-through timing the marked word is on `dout` one `rclk` edge later. With no mark active, `rt_n` has no effect.
- R8: While a mark is active, the marked word and every word after it count as occupied, so fullness is reached after (depth minus retained words) further writes. After the mark is released, space is returned.
- R9: A read while empty and a write while full are ignored: no word is lost, duplicated or inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks; latches the mode |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks; keeps the mode |
| mode_sel | input | 1 | Timing select sampled during master reset (0 standard, 1 fall-through) |
| din | input | DW | Write data |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| mark_i | input | 1 | Mark request, active high, read-clock domain |
| rt_n | input | 1 | Rewind to mark, active low, read-clock domain |
| dout | output | DW | Read data |
| rd_stat | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |
| wr_stat | output | 1 | Full flag (standard) or input-ready flag (fall-through) |

## Verification
The results become valid at different times. A standard-mode read shows its word at the read edge itself. A write clears the standard empty flag two read edges later, and reaches the output in fall-through mode on the third read edge. After a rewind in fall-through mode the marked word returns one read edge later. The write-side full flag rises on the write edge that fills the last free slot. The fall-through latency is checked edge by edge, one nanosecond after the second and after the third read edge. All other checks allow for the synchroniser delay and then sample at the opposite clock edge. A queue scoreboard compares every delivered word, including replayed words, against the order in which the words were written.

// File: rtl/fifo_rw_pkg.sv
`timescale 1ns/1ps
package fifo_rw_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // distance from b forward to a, modulo 2**pw
  function automatic logic [31:0] ptr_span(input logic [31:0] a, input logic [31:0] b,
                                            input int pw);
    return (a - b) & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/fifo_sync2.sv
`timescale 1ns/1ps
module fifo_sync2 #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else if (i == 0) st[i] <= d;
      else st[i] <= st[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
  import fifo_rw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          wen_n,
  input  logic [AW:0]   lim_gray_s,
  output logic [AW-1:0] waddr,
  output logic          wfire,
  output logic [AW:0]   wgray,
  output logic          wr_stat
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          rst, fwft_q, full;
  logic [AW:0]   wptr, wptr_nxt, lim_bin, wgray_q;

  assign rst      = !mrst_n || !prst_n;
  assign lim_bin  = PW'(gray2bin(32'(lim_gray_s)));
  assign full     = (wptr[AW] != lim_bin[AW]) && (wptr[AW-1:0] == lim_bin[AW-1:0]);
  assign wfire    = !wen_n && !full;
  assign wptr_nxt = wfire ? wptr + PW'(1) : wptr;

  always_ff @(posedge wclk) begin
    if (!mrst_n) fwft_q <= mode_sel;
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wptr    <= '0;
      wgray_q <= '0;
    end else begin
      wptr    <= wptr_nxt;
      wgray_q <= PW'(bin2gray(32'(wptr_nxt)));
    end
  end

  assign waddr   = wptr[AW-1:0];
  assign wgray   = wgray_q;
  assign wr_stat = fwft_q ? !full : full;

  // R1: the write pointer advances by at most one per edge
  a_r1_wptr_step: assert property (@(posedge wclk) disable iff (rst)
    1'b1 |=> (wptr == $past(wptr)) || (wptr == $past(wptr) + PW'(1)));

  // R8: never more than DEPTH words ahead of the oldest retained entry
  a_r8_wr_span: assert property (@(posedge wclk) disable iff (rst)
    ptr_span(32'(wptr), 32'(lim_bin), PW) <= 32'(DEPTH));
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
  import fifo_rw_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          ren_n,
  input  logic          mark_i,
  input  logic          rt_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   lim_gray,
  output logic [DW-1:0] dout,
  output logic          rd_stat
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          rst, fwft_q, out_valid, mark_act;
  logic          empty_int, rt_fire, mark_set, std_rd, fw_take, fw_fetch, rd_fire;
  logic [AW:0]   rptr, wsync_bin, head, mark_ptr, lim, lim_nxt, target, lim_gray_q;
  logic [DW-1:0] dout_q;

  assign rst       = !mrst_n || !prst_n;
  assign wsync_bin = PW'(gray2bin(32'(wgray_s)));
  assign empty_int = (rptr == wsync_bin);
  assign rt_fire   = !rt_n && mark_act;
  assign mark_set  = mark_i && !mark_act;
  assign std_rd    = !fwft_q && !ren_n && !empty_int && !rt_fire;
  assign fw_take   = fwft_q && out_valid && !ren_n && !rt_fire;
  assign fw_fetch  = fwft_q && !rt_fire && (!out_valid || fw_take) && !empty_int;
  assign rd_fire   = std_rd || fw_fetch;
  // oldest word the consumer has not yet taken
  assign head      = (fwft_q && out_valid) ? rptr - PW'(1) : rptr;
  assign target    = mark_act ? mark_ptr : head;
  assign lim_nxt   = (lim != target) ? lim + PW'(1) : lim;

  always_ff @(posedge rclk) begin
    if (!mrst_n) fwft_q <= mode_sel;
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rptr       <= '0;
      out_valid  <= 1'b0;
      dout_q     <= '0;
      mark_act   <= 1'b0;
      mark_ptr   <= '0;
      lim        <= '0;
      lim_gray_q <= '0;
    end else begin
      mark_act   <= mark_i;
      if (mark_set) mark_ptr <= head;
      lim        <= lim_nxt;
      lim_gray_q <= PW'(bin2gray(32'(lim_nxt)));
      if (rt_fire) begin
        rptr      <= mark_ptr;
        out_valid <= 1'b0;
      end else if (rd_fire) begin
        rptr      <= rptr + PW'(1);
        dout_q    <= rdata;
        out_valid <= fwft_q;
      end else if (fw_take) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign raddr    = rptr[AW-1:0];
  assign lim_gray = lim_gray_q;
  assign dout     = dout_q;
  assign rd_stat  = fwft_q ? out_valid : empty_int;

  // R2: standard timing holds the output when no read is requested
  a_r2_std_hold: assert property (@(posedge rclk) disable iff (rst)
    (!fwft_q && ren_n) |=> $stable(dout_q));
  // R9: a read on an empty buffer leaves the output alone
  a_r9_empty_hold: assert property (@(posedge rclk) disable iff (rst)
    (!fwft_q && empty_int) |=> $stable(dout_q));
  // R3: a presented word waits for the consumer
  a_r3_fwft_hold: assert property (@(posedge rclk) disable iff (rst)
    (fwft_q && out_valid && ren_n && !rt_fire) |=> (out_valid && $stable(dout_q)));
  // R7: rewind reloads the marked position
  a_r7_rt_reload: assert property (@(posedge rclk) disable iff (rst)
    rt_fire |=> (rptr == $past(mark_ptr)));
  // R9: the read pointer never passes the written data
  a_r9_rd_span: assert property (@(posedge rclk) disable iff (rst)
    ptr_span(32'(wsync_bin), 32'(rptr), PW) <= 32'(DEPTH));
  // R8: the exported limit moves in single steps, keeping its Gray code safe
  a_r8_lim_step: assert property (@(posedge rclk) disable iff (rst)
    1'b1 |=> (lim == $past(lim)) || (lim == $past(lim) + PW'(1)));
  // R4: the timing mode only changes under master reset
  a_r4_mode_hold: assert property (@(posedge rclk) disable iff (!mrst_n)
    mrst_n |=> $stable(fwft_q));
endmodule

// File: rtl/dcfifo_rewind.sv
`timescale 1ns/1ps
module dcfifo_rewind #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic [DW-1:0] din,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic          mark_i,
  input  logic          rt_n,
  output logic [DW-1:0] dout,
  output logic          rd_stat,
  output logic          wr_stat
);
  localparam int DEPTH = 1 << AW;

  logic          rst_any, wfire;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, wgray_s, lgray, lgray_s;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata;

  assign rst_any = !mrst_n || !prst_n;

  always_ff @(posedge wclk) begin
    if (wfire) mem[waddr] <= din;
  end
  assign rdata = mem[raddr];

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .wen_n(wen_n), .lim_gray_s(lgray_s), .waddr(waddr), .wfire(wfire),
    .wgray(wgray), .wr_stat(wr_stat)
  );

  fifo_sync2 #(.W(AW + 1)) u_wsync (.clk(rclk), .rst(rst_any), .d(wgray), .q(wgray_s));
  fifo_sync2 #(.W(AW + 1)) u_lsync (.clk(wclk), .rst(rst_any), .d(lgray), .q(lgray_s));

  fifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .ren_n(ren_n), .mark_i(mark_i), .rt_n(rt_n), .wgray_s(wgray_s),
    .rdata(rdata), .raddr(raddr), .lim_gray(lgray), .dout(dout), .rd_stat(rd_stat)
  );
endmodule

// File: tb/dcfifo_rewind_bench.sv
`timescale 1ns/1ps
module dcfifo_rewind_bench;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b1, prst_n = 1'b1, mode_sel = 1'b0;
  logic [DW-1:0] din = '0;
  logic wen_n = 1'b1, ren_n = 1'b1, mark_i = 1'b0, rt_n = 1'b1;
  logic [DW-1:0] dout;
  logic rd_stat, wr_stat;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] mk[$];

  dcfifo_rewind #(.DW(DW), .AW(AW)) u_dcfifo_rewind (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .din(din), .wen_n(wen_n), .ren_n(ren_n), .mark_i(mark_i), .rt_n(rt_n),
    .dout(dout), .rd_stat(rd_stat), .wr_stat(wr_stat)
  );

  always #2 wclk = ~wclk;
  initial begin
    #1.25;
    forever #3.5 rclk = ~rclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic do_reset(input bit master, input logic md);
    @(negedge rclk);
    mode_sel = md;
    if (master) mrst_n = 1'b0; else prst_n = 1'b0;
    wait_r(8);
    mrst_n = 1'b1;
    prst_n = 1'b1;
    wait_r(4);
    q.delete();
  endtask

  // driver: write one word, record it if it should be accepted
  task automatic push(input logic [DW-1:0] v, input bit accept);
    @(negedge wclk);
    din = v;
    wen_n = 1'b0;
    @(negedge wclk);
    wen_n = 1'b1;
    if (accept) q.push_back(v);
  endtask

  task automatic std_pop(input string req);
    logic [DW-1:0] e;
    @(negedge rclk) ren_n = 1'b0;
    @(negedge rclk) ren_n = 1'b1;
    e = (q.size() > 0) ? q.pop_front() : 'x;
    chk(req, 32'(dout), 32'(e));
  endtask

  task automatic fw_pop(input string req);
    logic [DW-1:0] e;
    @(negedge rclk);
    chk({req, " ready"}, 32'(rd_stat), 32'd1);
    e = (q.size() > 0) ? q.pop_front() : 'x;
    chk(req, 32'(dout), 32'(e));
    ren_n = 1'b0;
    @(negedge rclk) ren_n = 1'b1;
  endtask

  task automatic rewind;
    @(negedge rclk) rt_n = 1'b0;
    @(negedge rclk) rt_n = 1'b1;
  endtask

  initial begin
    // ---------- standard timing ----------
    do_reset(1'b1, 1'b0);
    chk("R4 std reset empty", 32'(rd_stat), 32'd1);
    chk("R4 std reset not full", 32'(wr_stat), 32'd0);

    push(16'h0011, 1); push(16'h0022, 1); push(16'h0033, 1);
    wait_r(6);
    chk("R2 data not shown before read", 32'(dout), 32'd0);
    chk("R2 not empty", 32'(rd_stat), 32'd0);
    for (int i = 0; i < 3; i++) std_pop("R1 R2 std read order");
    chk("R2 empty after drain", 32'(rd_stat), 32'd1);

    @(negedge rclk) ren_n = 1'b0;   // read while empty
    @(negedge rclk) ren_n = 1'b1;
    chk("R9 empty read keeps dout", 32'(dout), 32'h33);
    push(16'h0044, 1);
    wait_r(4);
    std_pop("R9 no pointer slip after empty read");

    wait_r(10);
    for (int i = 0; i < DEPTH; i++) push(16'h0050 + 16'(i), 1);
    chk("R4 std full flag", 32'(wr_stat), 32'd1);
    push(16'h00EE, 0);
    chk("R9 full stays full", 32'(wr_stat), 32'd1);
    for (int i = 0; i < DEPTH; i++) std_pop("R9 full drain order");
    chk("R9 rejected word absent", 32'(rd_stat), 32'd1);

    // mark coinciding with a read in standard timing
    wait_r(10);
    push(16'h00C0, 1); push(16'h00C1, 1); push(16'h00C2, 1);
    wait_r(6);
    mk = q;
    @(negedge rclk) begin ren_n = 1'b0; mark_i = 1'b1; end
    @(negedge rclk) ren_n = 1'b1;
    chk("R6 std marked read", 32'(dout), 32'(q.pop_front()));
    std_pop("R6 std read"); std_pop("R6 std read");
    chk("R6 drained", 32'(rd_stat), 32'd1);
    rewind();
    chk("R7 std rewind refills", 32'(rd_stat), 32'd0);
    q = mk;
    for (int i = 0; i < 3; i++) std_pop("R7 std replay");
    mark_i = 1'b0;

    // ---------- fall-through timing ----------
    do_reset(1'b1, 1'b1);
    chk("R4 fwft reset not ready", 32'(rd_stat), 32'd0);
    chk("R4 fwft reset input ready", 32'(wr_stat), 32'd1);

    @(negedge wclk) begin din = 16'h00A5; wen_n = 1'b0; end
    @(posedge wclk) wen_n <= 1'b1;
    q.push_back(16'h00A5);
    @(posedge rclk); @(posedge rclk); #1;
    chk("R3 not yet after two edges", 32'(rd_stat), 32'd0);
    @(posedge rclk); #1;
    chk("R3 ready at third edge", 32'(rd_stat), 32'd1);
    chk("R3 head word presented", 32'(dout), 32'h00A5);

    rewind();
    chk("R7 rewind without mark ignored", 32'(rd_stat), 32'd1);
    chk("R7 rewind without mark keeps word", 32'(dout), 32'h00A5);

    push(16'h00A6, 1); push(16'h00A7, 1);
    wait_r(8);
    chk("R3 later words wait for read", 32'(dout), 32'h00A5);
    for (int i = 0; i < 3; i++) fw_pop("R3 fwft consume order");
    wait_r(2);
    chk("R3 not ready when drained", 32'(rd_stat), 32'd0);

    // partial reset keeps fall-through timing
    push(16'h0031, 0); push(16'h0032, 0);
    wait_r(8);
    do_reset(1'b0, 1'b0);
    chk("R5 partial reset emptied", 32'(rd_stat), 32'd0);
    chk("R5 mode kept input ready", 32'(wr_stat), 32'd1);
    push(16'h0099, 1);
    wait_r(6);
    fw_pop("R5 fall-through after partial reset");

    // mark, fill behind it, rewind
    wait_r(10);
    for (int i = 0; i < 6; i++) push(16'h0060 + 16'(i), 1);
    wait_r(8);
    mk = q;
    @(negedge rclk) mark_i = 1'b1;
    @(negedge rclk);
    for (int i = 0; i < 6; i++) fw_pop("R6 fwft read under mark");
    wait_r(8);
    chk("R6 drained under mark", 32'(rd_stat), 32'd0);
    for (int i = 0; i < DEPTH - 6; i++) push(16'h0070 + 16'(i), 1);
    chk("R8 full counts marked words", 32'(wr_stat), 32'd0);
    push(16'h00EE, 0);
    rewind();
    q = {mk, q};
    for (int i = 0; i < DEPTH; i++) fw_pop("R7 fwft replay from mark");
    wait_r(2);
    chk("R7 replay drained", 32'(rd_stat), 32'd0);
    chk("R8 space held while marked", 32'(wr_stat), 32'd0);
    mark_i = 1'b0;
    wait_r(30);
    chk("R8 space returned after release", 32'(wr_stat), 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule